// File: doc/BRIEF.md
# Time-Keyed Variable-Order Round Cipher

This block encrypts one 64-bit data block under a 64-bit key over several dozen clock cycles. On a start request the key is first passed through a parallel self-synchronous scrambler so that long runs of identical bits are broken up. The scrambled key then drives eight chained rounds. Each round reads a 4-bit delay value from four fixed key positions and rotates the key left by one bit per clock until a counter reaches that value. The rotation cannot be collapsed into fewer clocks, so the time a round takes depends on the key itself.

Once a round's rotation is complete, the low byte of the rotated key is read as four 2-bit selectors. The selectors fix the order in which four reversible data functions run, one function per clock. Repeated selectors are resolved into a permutation, so each function runs exactly once per round. The data and the rotated key carry into the next round. After the eighth round the result is placed on the ciphertext output and the done flag is raised.

Top module: `tkc_cipher_top`

## Requirements
- R1: While reset is high and on the clock after it, `done` is 0 and `ciphertext` is all zeros.
- R2: The working key is the scrambled key. Processing runs from key bit 63 down to bit 0, with step i handling bit 63-i. Output bit s_i is the input bit XOR s_(i-14) XOR s_(i-15), where terms with a negative index are 0, and s_i is written to bit position 63-i.
- R3: At the start of every round the delay value T is {k[12], k[24], k[36], k[48]}, with k[12] as the most significant bit, taken from the round key as it stands before that round's rotation.
- R4: During a round the key is rotated left (bit 63 wraps into bit 0) by exactly one bit per clock, T times in total. With T = 0 the key is not rotated.
- R5: After rotation, selector j (j = 0..3) is bits [2j+1:2j] of the rotated key and chooses the function for step j. The codes are 00 = data XOR key, 01 = data + key mod 2^64, 10 = Gray code of (data XOR key), where g = x XOR (x >> 1), and 11 = bit reversal of the data.
- R6: A selector that names a function already used in this round is replaced by the next unused code counting upward from it, wrapping from 11 to 00.
- R7: Eight rounds run in sequence. Each round uses the previous round's data output and its rotated key.
- R8: The clock edge that samples `start` counts as edge 1. `done` first reads 1 after edge 1 + sum over the rounds of (T_r + 6), and `ciphertext` takes the result at that same edge.
- R9: While `done` is 1 and `start` is low, `done` stays 1 and `ciphertext` stays stable. A `start` pulse raised while a block is in progress is ignored.
- R10: A `start` pulse sampled while `done` is 1 clears `done` and begins a new block with the new inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a block; sampled only when idle |
| plaintext | input | 64 | Data block, sampled with start |
| key | input | 64 | Key, sampled with start |
| ciphertext | output | 64 | Result of the last completed block |
| done | output | 1 | High from completion until the next accepted start |

## Verification
Every internal slip in this block shows up at the ports in two ways. A wrong delay bit, a wrong rotation direction or an off-by-one count changes when `done` rises, and it also changes the key used in every later round. A wrong selector decode, a wrong permutation fix-up or a wrong data function appears only in the ciphertext, which is visible at the completion edge. The reference model therefore predicts both the exact cycle of completion and the result, and it compares `done` and `ciphertext` on every clock. A timing error is caught within one cycle of the predicted edge, and a data error is caught at completion.

// File: rtl/tkc_pkg.sv
package tkc_pkg;

    parameter int unsigned BLK_W   = 64;
    parameter int unsigned ROUNDS  = 8;
    parameter int unsigned NFUNC   = 4;
    parameter int unsigned TAP_A   = 14;
    parameter int unsigned TAP_B   = 15;
    parameter int unsigned POS_T3  = 12;
    parameter int unsigned POS_T2  = 24;
    parameter int unsigned POS_T1  = 36;
    parameter int unsigned POS_T0  = 48;

    localparam int unsigned SEL_W  = $clog2(NFUNC);
    localparam int unsigned TIME_W = 4;
    localparam int unsigned RND_W  = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
    localparam int unsigned STEP_W = (NFUNC > 1) ? $clog2(NFUNC) : 1;

    typedef logic [BLK_W-1:0]             word_t;
    typedef logic [SEL_W-1:0]             fsel_t;
    typedef fsel_t [NFUNC-1:0]            order_t;
    typedef logic [TIME_W-1:0]            tval_t;

    typedef enum logic [1:0] {
        FN_XOR  = 2'b00,
        FN_ADD  = 2'b01,
        FN_GRAY = 2'b10,
        FN_REV  = 2'b11
    } fn_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PREP = 2'd1,
        ST_ROT  = 2'd2,
        ST_MIX  = 2'd3
    } st_e;

    typedef struct packed {
        word_t          data;
        logic [RND_W-1:0]  rnd;
        logic [STEP_W-1:0] step;
        order_t         order;
    } dpath_t;

    function automatic word_t rotl1(input word_t w);
        return {w[BLK_W-2:0], w[BLK_W-1]};
    endfunction

    function automatic tval_t delay_of(input word_t w);
        return {w[POS_T3], w[POS_T2], w[POS_T1], w[POS_T0]};
    endfunction

    function automatic word_t bitrev(input word_t w);
        word_t r;
        for (int i = 0; i < int'(BLK_W); i++) r[i] = w[BLK_W-1-i];
        return r;
    endfunction

    function automatic word_t to_gray(input word_t w);
        return w ^ (w >> 1);
    endfunction

endpackage

// File: rtl/tkc_scrambler.sv
module tkc_scrambler
    import tkc_pkg::*;
(
    input  word_t kin,
    output word_t kout
);
    // Serial self-synchronous scrambler unrolled over the word, MSB handled first.
    word_t seq;

    always_comb begin
        seq = '0;
        for (int i = 0; i < int'(BLK_W); i++) begin
            logic b;
            b = kin[BLK_W-1-i];
            if (i >= int'(TAP_A)) b = b ^ seq[i-int'(TAP_A)];
            if (i >= int'(TAP_B)) b = b ^ seq[i-int'(TAP_B)];
            seq[i] = b;
        end
    end

    genvar g;
    generate
        for (g = 0; g < int'(BLK_W); g++) begin : g_map
            assign kout[BLK_W-1-g] = seq[g];
        end
    endgenerate
endmodule

// File: rtl/tkc_key_rotator.sv
module tkc_key_rotator
    import tkc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  word_t load_key,
    input  logic  arm,
    input  logic  step,
    output word_t key_q,
    output tval_t tgt_q,
    output tval_t cnt_q,
    output logic  hit
);
    always_ff @(posedge clk) begin
        if (rst) begin
            key_q <= '0;
            tgt_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            key_q <= load_key;
            cnt_q <= '0;
        end else if (arm) begin
            tgt_q <= delay_of(key_q);
            cnt_q <= '0;
        end else if (step) begin
            key_q <= rotl1(key_q);
            cnt_q <= cnt_q + tval_t'(1);
        end
    end

    assign hit = (cnt_q == tgt_q);
endmodule

// File: rtl/tkc_order_resolve.sv
module tkc_order_resolve
    import tkc_pkg::*;
(
    input  logic [NFUNC*SEL_W-1:0] sel_raw,
    output order_t                 order
);
    always_comb begin
        logic [NFUNC-1:0] used;
        used  = '0;
        order = '0;
        for (int j = 0; j < int'(NFUNC); j++) begin
            logic  found;
            fsel_t base;
            found = 1'b0;
            base  = sel_raw[j*SEL_W +: SEL_W];
            for (int k = 0; k < int'(NFUNC); k++) begin
                fsel_t cand;
                cand = fsel_t'(base + fsel_t'(k));
                if (!found && !used[cand]) begin
                    found       = 1'b1;
                    order[j]    = cand;
                    used[cand]  = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tkc_mix_unit.sv
module tkc_mix_unit
    import tkc_pkg::*;
(
    input  fsel_t sel,
    input  word_t din,
    input  word_t rkey,
    output word_t dout
);
    always_comb begin
        unique case (fn_e'(sel))
            FN_XOR:  dout = din ^ rkey;
            FN_ADD:  dout = din + rkey;
            FN_GRAY: dout = to_gray(din ^ rkey);
            FN_REV:  dout = bitrev(din);
            default: dout = din;
        endcase
    end
endmodule

// File: rtl/tkc_cipher_top.sv
module tkc_cipher_top
    import tkc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [63:0] plaintext,
    input  logic [63:0] key,
    output logic [63:0] ciphertext,
    output logic        done
);
    st_e    st;
    dpath_t dp;
    word_t  scr_key;
    word_t  rot_key;
    tval_t  rot_tgt;
    tval_t  rot_cnt;
    logic   rot_hit;
    order_t new_order;
    word_t  mix_out;
    word_t  ct_r;
    logic   done_r;
    logic   busy;

    logic accept, do_arm, do_step, do_fix;
    logic last_step, last_round;

    assign busy       = (st != ST_IDLE);
    assign accept     = (st == ST_IDLE) && start;
    assign do_arm     = (st == ST_PREP);
    assign do_step    = (st == ST_ROT) && !rot_hit;
    assign do_fix     = (st == ST_ROT) && rot_hit;
    assign last_step  = (dp.step == STEP_W'(NFUNC-1));
    assign last_round = (dp.rnd == RND_W'(ROUNDS-1));

    tkc_scrambler u_scr (
        .kin  (key),
        .kout (scr_key)
    );

    tkc_key_rotator u_rot (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_key (scr_key),
        .arm      (do_arm),
        .step     (do_step),
        .key_q    (rot_key),
        .tgt_q    (rot_tgt),
        .cnt_q    (rot_cnt),
        .hit      (rot_hit)
    );

    tkc_order_resolve u_ord (
        .sel_raw (rot_key[NFUNC*SEL_W-1:0]),
        .order   (new_order)
    );

    tkc_mix_unit u_mix (
        .sel  (dp.order[dp.step]),
        .din  (dp.data),
        .rkey (rot_key),
        .dout (mix_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            dp     <= '0;
            ct_r   <= '0;
            done_r <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        dp.data <= plaintext;
                        dp.rnd  <= '0;
                        dp.step <= '0;
                        done_r  <= 1'b0;
                        st      <= ST_PREP;
                    end
                end
                ST_PREP: st <= ST_ROT;
                ST_ROT: begin
                    if (rot_hit) begin
                        dp.order <= new_order;
                        dp.step  <= '0;
                        st       <= ST_MIX;
                    end
                end
                ST_MIX: begin
                    dp.data <= mix_out;
                    if (last_step) begin
                        if (last_round) begin
                            ct_r   <= mix_out;
                            done_r <= 1'b1;
                            st     <= ST_IDLE;
                        end else begin
                            dp.rnd <= dp.rnd + RND_W'(1);
                            st     <= ST_PREP;
                        end
                    end else begin
                        dp.step <= dp.step + STEP_W'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign ciphertext = ct_r;
    assign done       = done_r;

    logic unused_ok;
    assign unused_ok = do_fix ^ busy;
endmodule

// File: rtl/tkc_cipher_chk.sv
module tkc_cipher_chk
    import tkc_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   start,
    input logic   done,
    input word_t  ciphertext,
    input st_e    st,
    input word_t  rot_key,
    input tval_t  rot_tgt,
    input tval_t  rot_cnt,
    input order_t order
);
    logic perm_ok;
    always_comb begin
        logic [NFUNC-1:0] seen;
        seen = '0;
        for (int j = 0; j < int'(NFUNC); j++) seen[order[j]] = 1'b1;
        perm_ok = &seen;
    end

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!done && ciphertext == '0));

    // R4: one left rotation per counting clock
    a_r4_rotate_step: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ROT && rot_cnt != rot_tgt) |=> rot_key == rotl1($past(rot_key)));

    // R4: counter never passes the delay value
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ROT) |-> (rot_cnt <= rot_tgt));

    // R6: each function exactly once per round
    a_r6_perm: assert property (@(posedge clk) disable iff (rst)
        (st == ST_MIX) |-> perm_ok);

    // R8: completion only from the function stage
    a_r8_done_source: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(st) == ST_MIX));

    // R9
    a_r9_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(ciphertext)));

    a_r9_idle_when_done: assert property (@(posedge clk) disable iff (rst)
        done |-> (st == ST_IDLE));
endmodule

bind tkc_cipher_top tkc_cipher_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .done       (done),
    .ciphertext (ciphertext),
    .st         (st),
    .rot_key    (rot_key),
    .rot_tgt    (rot_tgt),
    .rot_cnt    (rot_cnt),
    .order      (dp.order)
);

// File: tb/sim_tkc_cipher_top.sv
`timescale 1ns/1ps
module sim_tkc_cipher_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [63:0] plaintext;
    logic [63:0] key;
    logic [63:0] ciphertext;
    logic        done;

    int checks = 0;
    int errors = 0;
    logic [63:0] last_ct = '0;

    always #4 clk = ~clk;

    tkc_cipher_top u0 (
        .clk(clk), .rst(rst), .start(start),
        .plaintext(plaintext), .key(key),
        .ciphertext(ciphertext), .done(done)
    );

    // ---------------- behavioural reference ----------------
    function automatic logic [63:0] m_scramble(input logic [63:0] k);
        bit q[$];
        logic [63:0] o;
        for (int i = 0; i < 64; i++) begin
            bit b;
            b = k[63-i];
            if (i >= 14) b ^= q[i-14];
            if (i >= 15) b ^= q[i-15];
            q.push_back(b);
            o[63-i] = b;
        end
        return o;
    endfunction

    function automatic logic [63:0] m_rot(input logic [63:0] k, input int t);
        if (t == 0) return k;
        return (k << t) | (k >> (64 - t));
    endfunction

    function automatic logic [63:0] m_apply(input int f, input logic [63:0] d, input logic [63:0] k);
        logic [63:0] x, r;
        case (f)
            0: return d ^ k;
            1: return d + k;
            2: begin x = d ^ k; return x ^ (x >> 1); end
            default: begin
                for (int i = 0; i < 64; i++) r[63-i] = d[i];
                return r;
            end
        endcase
    endfunction

    task automatic model(input logic [63:0] pt, input logic [63:0] k0,
                         output logic [63:0] ct, output int lat);
        logic [63:0] k, d;
        k = m_scramble(k0);
        d = pt;
        lat = 1;
        for (int r = 0; r < 8; r++) begin
            int t;
            int used[4];
            t = {28'd0, k[12], k[24], k[36], k[48]};
            lat += t + 6;
            k = m_rot(k, t);
            used = '{0, 0, 0, 0};
            for (int j = 0; j < 4; j++) begin
                int f;
                f = int'(k[2*j +: 2]);
                while (used[f] != 0) f = (f + 1) % 4;
                used[f] = 1;
                d = m_apply(f, d, k);
            end
        end
        ct = d;
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One block; inject=1 raises a stray start mid-run (R9).
    task automatic run_case(input logic [63:0] pt, input logic [63:0] k,
                            input bit inject, input string req);
        logic [63:0] exp;
        int lat;
        model(pt, k, exp, lat);
        @(negedge clk);
        plaintext = pt; key = k; start = 1'b1;
        for (int n = 1; n <= lat + 2; n++) begin
            @(posedge clk);
            @(negedge clk);
            start = (inject && n == 10);
            if (inject && n == 10) begin plaintext = ~pt; key = ~k; end
            // R8 / R10: done tracks the predicted completion edge
            chk(done == (n >= lat), "R8 done timing", {63'd0, done}, {63'd0, n >= lat});
            chk(ciphertext == ((n >= lat) ? exp : last_ct), req, ciphertext,
                (n >= lat) ? exp : last_ct);
        end
        last_ct = exp;
        start = 1'b0;
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; plaintext = '0; key = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R1 done in reset", {63'd0, done}, 64'd0);
        chk(ciphertext == '0, "R1 ct in reset", ciphertext, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0 && ciphertext == '0, "R1 after reset", ciphertext, 64'd0);

        // R3/R4 zero delay every round, R5 straight order 0,1,2,3
        run_case(64'h0123_4567_89AB_CDEF, 64'h0, 1'b0, "R5 zero key order");
        // R2 scrambler on all ones, R6 repeated selectors
        run_case(64'hFFFF_0000_FFFF_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R2 R6 ones key");
        // R3/R4 nonzero delays from key positions
        run_case(64'h0, 64'h0001_0010_0100_1000, 1'b0, "R3 R4 delay bits");
        run_case(64'hDEAD_BEEF_CAFE_F00D, 64'h1357_9BDF_0246_8ACE, 1'b0, "R7 chained rounds");
        // R9 stray start while busy; R10 restart from done
        run_case(64'hA5A5_5A5A_3C3C_C3C3, 64'h8000_0000_0000_0001, 1'b1, "R9 start ignored");
        run_case(64'hFFFF_FFFF_FFFF_FFFF, 64'hF0F0_F0F0_0F0F_0F0F, 1'b0, "R10 restart");
        begin
            logic [63:0] s;
            s = 64'h9E37_79B9_7F4A_7C15;
            for (int v = 0; v < 6; v++) begin
                s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
                run_case(~s, s, v[0], "R7 pattern");
            end
        end
        // R9: done holds with start low
        repeat (5) begin
            @(negedge clk);
            chk(done == 1'b1 && ciphertext == last_ct, "R9 hold", ciphertext, last_ct);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule